// File: doc/BRIEF.md
# Bus Debug Trigger Comparator

This block observes each transfer presented on an on-chip system bus and produces two kinds of debug trigger event. The address trigger compares the transfer address with a programmed reference address. The mode can be "equal", "unsigned greater or equal" or "off". The status trigger looks at the transfer's opcode and its supervisor, write and read signals. By default it accepts any opcode other than the idle (no-operation) code. Per-signal qualifiers can then demand that each selected signal equals a programmed expected value.

A small register write port holds the configuration. Software or a debug controller writes a select code and a data word with a one-cycle strobe. Each trigger is registered and appears as a one-cycle pulse on the clock edge after the matching transfer. Downstream logic for sequencing and break actions consumes these pulses.

Top module: `bus_dbg_trig`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every configuration register to zero and drives both trigger outputs low. With the cleared configuration, no transfer raises any trigger.
- R2: With address mode field value 2'b00, addr_trig never rises.
- R3: With address mode 2'b01, addr_trig pulses exactly when a valid transfer's address equals the reference address.
- R4: With address mode 2'b10, addr_trig pulses when a valid transfer's address is greater than or equal to the reference. The comparison is unsigned over all ADDR_W bits.
- R5: Address mode 2'b11 behaves like 2'b00: addr_trig never rises.
- R6: When the status enable bit is 1 and the opcode qualifier bit is 0, the opcode condition holds for every opcode except all ones (4'hF, the idle code).
- R7: When the opcode qualifier bit is 1, the opcode condition holds only when the bus opcode equals the programmed opcode. This includes a programmed 4'hF.
- R8: When the supervisor qualifier bit is 1, the status trigger also requires bus_sv to equal the programmed supervisor value. When that bit is 0, bus_sv has no effect.
- R9: The write and read qualifier bits each, when 1, require bus_wr or bus_rd to equal its own programmed value. When a bit is 0, its signal has no effect.
- R10: stat_trig is the AND of the status enable bit, the opcode condition and every enabled qualifier. Both triggers are evaluated only when bus_valid is 1.
- R11: Each trigger is registered. It is high for exactly the one cycle after the clock edge that sampled the matching transfer, and it is low after an edge where bus_valid was 0.
- R12: A write (cfg_we=1) is decoded by cfg_sel. Select 0 loads the control word: [1:0] address mode, [2] opcode qualifier, [3] supervisor qualifier, [4] write qualifier, [5] read qualifier, [6] status enable. Select 1 loads the reference address. Select 2 loads the expected values: [3:0] opcode, [4] supervisor, [5] write, [6] read. Select 3 changes nothing. A write takes effect for transfers sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| bus_valid | input | 1 | A transfer is presented this cycle |
| bus_addr | input | ADDR_W | Transfer address |
| bus_opc | input | OPC_W | Transfer opcode, all ones = idle |
| bus_sv | input | 1 | Supervisor-mode signal |
| bus_wr | input | 1 | Write signal |
| bus_rd | input | 1 | Read signal |
| addr_trig | output | 1 | Address trigger pulse |
| stat_trig | output | 1 | Status trigger pulse |

## Verification
Several properties are checked on every cycle by embedded assertions. The off address modes never fire. Equal mode never fires on a differing address. Greater-or-equal mode follows the unsigned order in both directions. The idle opcode never fires the status trigger when it is the only condition, and a mismatching supervisor value blocks the status trigger. Idle cycles leave both outputs low, and select 3 leaves the registers unchanged. Other behaviour can only be shown by the bench's scenarios. These include the exact register bit positions, a write taking effect on the next transfer, the AND of several qualifiers together, and the boundary addresses around the reference: one below, equal, all ones, and zero.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  // address compare selection; the encoding is fixed by the control word
  typedef enum logic [1:0] {
    AM_OFF  = 2'b00,
    AM_EQ   = 2'b01,
    AM_GE   = 2'b10,
    AM_OFF2 = 2'b11
  } amode_e;

  // control word, packed so that bit positions follow the select-0 layout
  typedef struct packed {
    logic   stat_en;  // [6]
    logic   rd_q;     // [5]
    logic   wr_q;     // [4]
    logic   sv_q;     // [3]
    logic   opc_q;    // [2]
    amode_e mode;     // [1:0]
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_REF  = 2'd1;
  localparam logic [1:0] SEL_EXP  = 2'd2;

endpackage

// File: rtl/bdt_regs.sv
module bdt_regs
  import bdt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] ref_addr,
  output logic [OPC_W-1:0]  exp_opc,
  output logic              exp_sv,
  output logic              exp_wr,
  output logic              exp_rd
);

  localparam int SV_BIT = OPC_W;
  localparam int WR_BIT = OPC_W + 1;
  localparam int RD_BIT = OPC_W + 2;

  logic wr_ctrl, wr_ref, wr_exp;
  assign wr_ctrl = we && (sel == SEL_CTRL);
  assign wr_ref  = we && (sel == SEL_REF);
  assign wr_exp  = we && (sel == SEL_EXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      ref_addr <= '0;
      exp_opc  <= '0;
      exp_sv   <= 1'b0;
      exp_wr   <= 1'b0;
      exp_rd   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_ref)  ref_addr <= wdata;
      if (wr_exp) begin
        exp_opc <= wdata[OPC_W-1:0];
        exp_sv  <= wdata[SV_BIT];
        exp_wr  <= wdata[WR_BIT];
        exp_rd  <= wdata[RD_BIT];
      end
    end
  end

  // R12
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd3) |=> ($stable(ctrl) && $stable(ref_addr) && $stable(exp_opc)
                             && $stable(exp_sv) && $stable(exp_wr) && $stable(exp_rd)));

  // R12
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ctrl) && $stable(ref_addr)));

endmodule

// File: rtl/bdt_addr_cmp.sv
module bdt_addr_cmp
  import bdt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  amode_e            mode,
  output logic              hit,
  output logic              trig
);

  // unsigned compare selected by mode; both off codes give no hit
  function automatic logic addr_match(input amode_e m,
                                      input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] r);
    logic res;
    case (m)
      AM_EQ:   res = (a == r);
      AM_GE:   res = (a >= r);
      default: res = 1'b0;
    endcase
    return res;
  endfunction

  assign hit = valid && addr_match(mode, addr, ref_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= hit;
  end

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_OFF) |=> !trig);

  // R5
  mode_off2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_OFF2) |=> !trig);

  // R3
  eq_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == AM_EQ && addr != ref_addr) |=> !trig);

  // R4
  ge_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == AM_GE && addr < ref_addr) |=> !trig);

  // R4
  ge_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mode == AM_GE && !(addr < ref_addr)) |=> trig);

  // R11
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !trig);

endmodule

// File: rtl/bdt_status_cmp.sv
module bdt_status_cmp
  import bdt_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [OPC_W-1:0] opc,
  input  logic             sv,
  input  logic             wr,
  input  logic             rd,
  input  ctrl_t            ctrl,
  input  logic [OPC_W-1:0] exp_opc,
  input  logic             exp_sv,
  input  logic             exp_wr,
  input  logic             exp_rd,
  output logic             opc_ok,
  output logic             sig_ok,
  output logic             hit,
  output logic             trig
);

  localparam logic [OPC_W-1:0] IDLE_OPC = '1;

  function automatic logic opc_match(input logic q,
                                     input logic [OPC_W-1:0] o,
                                     input logic [OPC_W-1:0] e);
    return q ? (o == e) : (o != IDLE_OPC);
  endfunction

  // a qualifier that is off always passes
  function automatic logic qual_pass(input logic q, input logic s, input logic e);
    return !q || (s == e);
  endfunction

  assign opc_ok = opc_match(ctrl.opc_q, opc, exp_opc);
  assign sig_ok = qual_pass(ctrl.sv_q, sv, exp_sv)
               && qual_pass(ctrl.wr_q, wr, exp_wr)
               && qual_pass(ctrl.rd_q, rd, exp_rd);
  assign hit    = valid && ctrl.stat_en && opc_ok && sig_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= hit;
  end

  // R6
  idle_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.opc_q && opc == IDLE_OPC) |=> !trig);

  // R6
  any_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.stat_en && !ctrl.opc_q && !ctrl.sv_q && !ctrl.wr_q && !ctrl.rd_q
     && opc != IDLE_OPC) |=> trig);

  // R8
  sv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.sv_q && sv != exp_sv) |=> !trig);

  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.stat_en |=> !trig);

  // R11
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !trig);

endmodule

// File: rtl/bus_dbg_trig.sv
module bus_dbg_trig
  import bdt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [OPC_W-1:0]  bus_opc,
  input  logic              bus_sv,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              addr_trig,
  output logic              stat_trig
);

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] ref_addr;
  logic [OPC_W-1:0]  exp_opc;
  logic              exp_sv, exp_wr, exp_rd;

  // internal events brought out by name for the checks below
  logic addr_hit, stat_hit, opc_ok, sig_ok;

  bdt_regs #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .ctrl     (ctrl),
    .ref_addr (ref_addr),
    .exp_opc  (exp_opc),
    .exp_sv   (exp_sv),
    .exp_wr   (exp_wr),
    .exp_rd   (exp_rd)
  );

  bdt_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (bus_valid),
    .addr     (bus_addr),
    .ref_addr (ref_addr),
    .mode     (ctrl.mode),
    .hit      (addr_hit),
    .trig     (addr_trig)
  );

  bdt_status_cmp #(.OPC_W(OPC_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (bus_valid),
    .opc     (bus_opc),
    .sv      (bus_sv),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .ctrl    (ctrl),
    .exp_opc (exp_opc),
    .exp_sv  (exp_sv),
    .exp_wr  (exp_wr),
    .exp_rd  (exp_rd),
    .opc_ok  (opc_ok),
    .sig_ok  (sig_ok),
    .hit     (stat_hit),
    .trig    (stat_trig)
  );

  // R11
  addr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_trig |-> $past(bus_valid));

  // R11
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_trig |-> ($past(bus_valid) && $past(opc_ok) && $past(sig_ok)));

  // R10
  stat_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(opc_ok && sig_ok)) |=> !stat_trig);

endmodule

// File: tb/bus_dbg_trig_bench.sv
module bus_dbg_trig_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [OW-1:0] bus_opc = '0;
  logic          bus_sv = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic          addr_trig, stat_trig;

  bus_dbg_trig #(.ADDR_W(AW), .OPC_W(OW)) u_bus_dbg_trig (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_opc(bus_opc),
    .bus_sv(bus_sv), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .addr_trig(addr_trig), .stat_trig(stat_trig)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench's own view of the configuration, kept from the register map
  logic [1:0]    m_mode = '0;
  logic          m_oq = 0, m_sq = 0, m_wq = 0, m_rq = 0, m_en = 0;
  logic [AW-1:0] m_ref = '0;
  logic [OW-1:0] m_opc = '0;
  logic          m_sv = 0, m_wr = 0, m_rd = 0;

  function automatic bit want_addr(input logic [AW-1:0] a);
    if (m_mode == 2'b01) return a == m_ref;
    if (m_mode == 2'b10) return !(a < m_ref);
    return 1'b0;
  endfunction

  function automatic bit want_stat(input logic [OW-1:0] o, input logic s,
                                   input logic w, input logic r);
    if (!m_en) return 1'b0;
    if (m_oq && o != m_opc) return 1'b0;
    if (!m_oq && o == 4'hF) return 1'b0;
    if (m_sq && s != m_sv) return 1'b0;
    if (m_wq && w != m_wr) return 1'b0;
    if (m_rq && r != m_rd) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    case (sel)
      2'd0: begin
        m_mode = d[1:0]; m_oq = d[2]; m_sq = d[3]; m_wq = d[4]; m_rq = d[5]; m_en = d[6];
      end
      2'd1: m_ref = d;
      2'd2: begin m_opc = d[3:0]; m_sv = d[4]; m_wr = d[5]; m_rd = d[6]; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xfer(input string req, input logic v, input logic [AW-1:0] a,
                      input logic [OW-1:0] o, input logic s, input logic w, input logic r);
    bit ea, es;
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_opc = o; bus_sv = s; bus_wr = w; bus_rd = r;
    ea = v && want_addr(a);
    es = v && want_stat(o, s, w, r);
    @(negedge clk);
    check(req, "addr_trig", addr_trig, ea);
    check(req, "stat_trig", stat_trig, es);
    bus_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "addr_trig reset", addr_trig, 1'b0);
    check("R1", "stat_trig reset", stat_trig, 1'b0);
    rst_n = 1'b1;
    xfer("R1", 1, 32'h0, 4'h0, 0, 0, 0);
    xfer("R1", 1, 32'h1234, 4'h3, 1, 1, 0);

    // R3: equal mode, reference with MSB set
    wr_reg(2'd1, 32'h8000_0000);
    wr_reg(2'd0, 32'h01);
    xfer("R3", 1, 32'h8000_0000, 4'h0, 0, 0, 0);
    xfer("R3", 1, 32'h8000_0001, 4'h0, 0, 0, 0);
    xfer("R3", 1, 32'h7FFF_FFFF, 4'h0, 0, 0, 0);
    // R11: pulse then idle, and a matching address with bus_valid low
    xfer("R11", 1, 32'h8000_0000, 4'h0, 0, 0, 0);
    xfer("R11", 0, 32'h8000_0000, 4'h0, 0, 0, 0);

    // R4: unsigned greater-or-equal boundaries
    wr_reg(2'd0, 32'h02);
    xfer("R4", 1, 32'h7FFF_FFFF, 4'h0, 0, 0, 0);
    xfer("R4", 1, 32'h8000_0000, 4'h0, 0, 0, 0);
    xfer("R4", 1, 32'hFFFF_FFFF, 4'h0, 0, 0, 0);
    xfer("R4", 1, 32'h0000_0000, 4'h0, 0, 0, 0);

    // R5 and R2: off modes with an equal address
    wr_reg(2'd0, 32'h03);
    xfer("R5", 1, 32'h8000_0000, 4'h0, 0, 0, 0);
    xfer("R5", 1, 32'hFFFF_FFFF, 4'h0, 0, 0, 0);
    wr_reg(2'd0, 32'h00);
    xfer("R2", 1, 32'h8000_0000, 4'h0, 0, 0, 0);

    // R6: any opcode except idle
    wr_reg(2'd0, 32'h40);
    xfer("R6", 1, 32'h10, 4'hF, 0, 0, 0);
    xfer("R6", 1, 32'h10, 4'h0, 1, 1, 1);
    xfer("R6", 1, 32'h10, 4'hE, 0, 0, 1);

    // R7: programmed opcode, including the idle code
    wr_reg(2'd2, 32'h05);
    wr_reg(2'd0, 32'h44);
    xfer("R7", 1, 32'h10, 4'h5, 0, 0, 0);
    xfer("R7", 1, 32'h10, 4'h6, 0, 0, 0);
    wr_reg(2'd2, 32'h0F);
    xfer("R7", 1, 32'h10, 4'hF, 0, 0, 0);

    // R8: supervisor qualifier, expected 1
    wr_reg(2'd2, 32'h10);
    wr_reg(2'd0, 32'h48);
    xfer("R8", 1, 32'h10, 4'h2, 0, 0, 0);
    xfer("R8", 1, 32'h10, 4'h2, 1, 0, 0);
    wr_reg(2'd0, 32'h40);
    xfer("R8", 1, 32'h10, 4'h2, 0, 0, 0);

    // R9: write expected 1, read expected 0
    wr_reg(2'd2, 32'h20);
    wr_reg(2'd0, 32'h50);
    xfer("R9", 1, 32'h10, 4'h1, 0, 1, 1);
    xfer("R9", 1, 32'h10, 4'h1, 0, 0, 1);
    wr_reg(2'd0, 32'h60);
    xfer("R9", 1, 32'h10, 4'h1, 0, 1, 0);
    xfer("R9", 1, 32'h10, 4'h1, 0, 1, 1);

    // R10: all qualifiers together, one mismatch at a time
    wr_reg(2'd2, 32'h73);
    wr_reg(2'd0, 32'h7D);
    xfer("R10", 1, 32'h10, 4'h3, 1, 1, 1);
    xfer("R10", 1, 32'h10, 4'h3, 1, 1, 0);
    xfer("R10", 1, 32'h10, 4'h2, 1, 1, 1);
    xfer("R10", 0, 32'h10, 4'h3, 1, 1, 1);

    // R12: select 3 must leave everything as it was
    wr_reg(2'd3, 32'hFFFF_FFFF);
    xfer("R12", 1, 32'h10, 4'h3, 1, 1, 1);
    xfer("R12", 1, 32'h10, 4'hF, 0, 0, 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      if (i % 25 == 0) begin
        wr_reg(2'($urandom_range(0, 3)), $urandom);
        wr_reg(2'd0, 32'($urandom_range(0, 127)));
        wr_reg(2'd2, 32'($urandom_range(0, 127)));
      end
      begin
        logic [AW-1:0] a;
        int pick;
        pick = $urandom_range(0, 3);
        case (pick)
          0: a = m_ref;
          1: a = m_ref - 1;
          2: a = m_ref + 1;
          default: a = $urandom;
        endcase
        xfer("R10", ($urandom_range(0, 7) != 0), a, 4'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    finish_run();
  end
endmodule